// File: doc/BRIEF.md
# Multi-Lane SPI Byte Shifter

This block is the bit-level engine under a serial flash controller. A sequencer above it hands over one byte-sized command at a time through a valid/ready handshake. Each command carries five things: a clock divider, a lane width, a direction flag, an SCK cycle count and a byte to send. The block then drives SCK and one, two or four data lanes, each lane with its own output enable. Chip select, address sequencing and any register access stay with the sequencer.

The same command format covers every kind of transfer. A full byte is a command whose count matches the lane width. Dummy cycles and the idle clocks sent after power-up are a transmit command with any count from one to eight clocks. Receive commands return the captured byte with a one-cycle acknowledge some cycles after acceptance. The block signals bus idle whenever nothing is shifting. It accepts the next command in the cycle right after the last falling SCK edge, so consecutive bytes leave no gap on the wire.

Top module: `spi_lane_shifter`

## Requirements
- R1: SCK idles low. With divider value d, SCK stays low for d+1 clock cycles after acceptance, then alternates high and low phases of d+1 cycles each, so its frequency is clk/((d+1)*2).
- R2: Transmit uses mode bit 0 = 1. Mode bits [2:1] select the width: 01 single, 10 dual, 11 quad (00 behaves as single). The enabled lanes are lane 0, lanes 1:0 or lanes 3:0. The most significant bit group goes first, and the higher-numbered lane carries the higher-order bit. Data changes only on falling SCK edges.
- R3: The 3-bit count field gives the number of SCK cycles minus one. 111, 011 and 001 move a full byte in single, dual and quad width.
- R4: A command is accepted on a clock edge where cmd_valid and cmd_ready are both high. cmd_ready is low from the cycle after acceptance until the command is finished.
- R5: A receive command (mode bit 0 = 0) samples inputs on rising SCK edges, MSB group first. Single width reads lane 1, dual reads lanes 1:0, quad reads lanes 3:0. The byte appears on rx_data while rx_ack is high for exactly one cycle, 2*(d+1)*(count+1) cycles after the accepting edge.
- R6: During a receive command every output enable is low.
- R7: bus_idle is low from the cycle after acceptance until the last falling SCK edge of the command, and high otherwise.
- R8: The next command can be accepted on the edge right after the cycle in which bus_idle returns high, with no idle clock between bytes.
- R9: A synchronous reset, even in the middle of a command, returns SCK low, clears all output enables, cancels any pending acknowledge and drives bus_idle and cmd_ready high.
- R10: A transmit command with a short count, such as a dummy-cycle burst, produces exactly count+1 SCK cycles and no rx_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| div_i | input | DIV_W | Clock divider for the command |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine can take a command |
| cmd_mode | input | 3 | Width in [2:1], transmit flag in [0] |
| cmd_clks | input | 3 | SCK cycles minus one |
| cmd_txd | input | 8 | Byte to transmit |
| rx_data | output | 8 | Received byte |
| rx_ack | output | 1 | One-cycle pulse, rx_data valid |
| bus_idle | output | 1 | No command shifting |
| sck | output | 1 | Serial clock |
| sdat_o | output | LANES | Lane output data |
| sdat_oe | output | LANES | Per-lane output enable |
| sdat_i | input | LANES | Lane input data |

## Verification
The hardest situation to reach is the hand-off between two commands. The last falling edge of one command, its acknowledge and the acceptance of the next all fall within two cycles. The stimulus queues a quad receive with the smallest divider and offers a dual transmit as soon as ready returns. It then checks that the acknowledge arrives at its computed cycle and that the second acceptance follows with no spare cycle. A reset asserted halfway through a receive is the other hard case: the bench checks that no late acknowledge ever escapes.

// File: rtl/spi_shift_pkg.sv
package spi_shift_pkg;

    typedef enum logic [1:0] {
        LW_RSVD = 2'b00,
        LW_ONE  = 2'b01,
        LW_TWO  = 2'b10,
        LW_FOUR = 2'b11
    } lane_w_e;

    typedef struct packed {
        logic       busy;
        logic       is_tx;
        lane_w_e    width;
        logic [2:0] left;
        logic [7:0] txsr;
        logic [7:0] rxsr;
        logic       ack;
        logic [7:0] rxd;
    } shift_st_t;

    // Shift a byte left by one lane group, filling from the right.
    function automatic logic [7:0] shift_group(input logic [7:0] v,
                                               input lane_w_e w,
                                               input logic [3:0] fill);
        case (w)
            LW_FOUR: shift_group = {v[3:0], fill};
            LW_TWO:  shift_group = {v[5:0], fill[1:0]};
            default: shift_group = {v[6:0], fill[0]};
        endcase
    endfunction

endpackage

// File: rtl/spi_sck_gen.sv
module spi_sck_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             sck_o,
    output logic             rise_o,
    output logic             fall_o
);
    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [DIV_W-1:0] cnt;
        logic             sck;
    } sck_st_t;

    sck_st_t s_q, s_d;
    logic    phase_end;

    assign phase_end = run_i && (s_q.cnt == '0);
    assign rise_o    = phase_end && !s_q.sck;
    assign fall_o    = phase_end &&  s_q.sck;
    assign sck_o     = s_q.sck;

    always_comb begin
        s_d = s_q;
        if (load_i) begin
            s_d.div = div_i;
            s_d.cnt = div_i;
            s_d.sck = 1'b0;
        end else if (run_i) begin
            if (s_q.cnt == '0) begin
                s_d.sck = !s_q.sck;
                s_d.cnt = s_q.div;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    // R1: each phase ends on a counter expiry, so SCK holds between them
    p_sck_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !rise_o && !fall_o) |=> $stable(sck_o));
endmodule

// File: rtl/spi_lane_map.sv
module spi_lane_map
    import spi_shift_pkg::*;
#(
    parameter int LANES = 4
) (
    input  lane_w_e          width_i,
    input  logic             drive_i,
    input  logic [3:0]       lead_i,
    input  logic [LANES-1:0] sdat_i,
    output logic [LANES-1:0] sdat_o,
    output logic [LANES-1:0] sdat_oe,
    output logic [3:0]       sample_o
);
    localparam int MISO_IDX = (LANES > 1) ? 1 : 0;

    logic [3:0] in_pad, out_pad, mask;

    assign in_pad = 4'(sdat_i);

    always_comb begin
        case (width_i)
            LW_FOUR: begin
                out_pad  = lead_i;
                mask     = 4'hF;
                sample_o = in_pad;
            end
            LW_TWO: begin
                out_pad  = {2'b00, lead_i[3:2]};
                mask     = 4'h3;
                sample_o = {2'b00, in_pad[1:0]};
            end
            default: begin
                out_pad  = {3'b000, lead_i[3]};
                mask     = 4'h1;
                sample_o = {3'b000, in_pad[MISO_IDX]};
            end
        endcase
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign sdat_o[i]  = out_pad[i];
        assign sdat_oe[i] = drive_i & mask[i];
    end
endmodule

// File: rtl/spi_lane_shifter.sv
module spi_lane_shifter
    import spi_shift_pkg::*;
#(
    parameter int LANES = 4,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_i,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [2:0]       cmd_mode,
    input  logic [2:0]       cmd_clks,
    input  logic [7:0]       cmd_txd,
    output logic [7:0]       rx_data,
    output logic             rx_ack,
    output logic             bus_idle,
    output logic             sck,
    output logic [LANES-1:0] sdat_o,
    output logic [LANES-1:0] sdat_oe,
    input  logic [LANES-1:0] sdat_i
);
    shift_st_t  st_q, st_d;
    logic       accept, rise, fall;
    logic [3:0] sample;

    assign cmd_ready = !st_q.busy;
    assign accept    = cmd_valid && cmd_ready;
    assign rx_data   = st_q.rxd;
    assign rx_ack    = st_q.ack;
    assign bus_idle  = !st_q.busy;

    spi_sck_gen #(.DIV_W(DIV_W)) u_sck (
        .clk    (clk),
        .rst    (rst),
        .load_i (accept),
        .run_i  (st_q.busy),
        .div_i  (div_i),
        .sck_o  (sck),
        .rise_o (rise),
        .fall_o (fall)
    );

    spi_lane_map #(.LANES(LANES)) u_map (
        .width_i  (st_q.width),
        .drive_i  (st_q.busy && st_q.is_tx),
        .lead_i   (st_q.txsr[7:4]),
        .sdat_i   (sdat_i),
        .sdat_o   (sdat_o),
        .sdat_oe  (sdat_oe),
        .sample_o (sample)
    );

    always_comb begin
        st_d     = st_q;
        st_d.ack = 1'b0;
        if (accept) begin
            st_d.busy  = 1'b1;
            st_d.is_tx = cmd_mode[0];
            st_d.width = (cmd_mode[2:1] == 2'b00) ? LW_ONE : lane_w_e'(cmd_mode[2:1]);
            st_d.left  = cmd_clks;
            st_d.txsr  = cmd_txd;
            st_d.rxsr  = '0;
        end else if (st_q.busy) begin
            if (rise) begin
                st_d.rxsr = shift_group(st_q.rxsr, st_q.width, sample);
            end
            if (fall) begin
                if (st_q.left == 3'd0) begin
                    st_d.busy = 1'b0;
                    st_d.ack  = !st_q.is_tx;
                    if (!st_q.is_tx) st_d.rxd = st_q.rxsr;
                end else begin
                    st_d.left = st_q.left - 3'd1;
                    st_d.txsr = shift_group(st_q.txsr, st_q.width, 4'h0);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    p_ack_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        rx_ack |=> !rx_ack);
    p_ack_at_idle_r5: assert property (@(posedge clk) disable iff (rst)
        rx_ack |-> bus_idle);
    p_accept_busy_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> (!bus_idle && !cmd_ready));
    p_idle_sck_low_r1: assert property (@(posedge clk) disable iff (rst)
        bus_idle |-> !sck);
    p_oe_needs_busy_r7: assert property (@(posedge clk) disable iff (rst)
        (|sdat_oe) |-> !bus_idle);
    p_rx_no_oe_r6: assert property (@(posedge clk) disable iff (rst)
        (!bus_idle && !st_q.is_tx) |-> (sdat_oe == '0));
    p_data_hold_high_r2: assert property (@(posedge clk) disable iff (rst)
        (sck && $past(sck)) |-> $stable(sdat_o));
    p_reset_state_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (bus_idle && !sck && !rx_ack && sdat_oe == '0));
endmodule

// File: tb/spi_lane_shifter_tb.sv
module spi_lane_shifter_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] div_i = '0;
    logic       cmd_valid = 1'b0;
    logic       cmd_ready;
    logic [2:0] cmd_mode = '0;
    logic [2:0] cmd_clks = '0;
    logic [7:0] cmd_txd = '0;
    logic [7:0] rx_data;
    logic       rx_ack, bus_idle, sck;
    logic [3:0] sdat_o, sdat_oe;
    logic [3:0] sdat_i = '0;

    always #4 clk = ~clk;

    spi_lane_shifter u_dut (
        .clk(clk), .rst(rst), .div_i(div_i), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .cmd_mode(cmd_mode), .cmd_clks(cmd_clks),
        .cmd_txd(cmd_txd), .rx_data(rx_data), .rx_ack(rx_ack),
        .bus_idle(bus_idle), .sck(sck), .sdat_o(sdat_o),
        .sdat_oe(sdat_oe), .sdat_i(sdat_i)
    );

    typedef struct { int b; int at; } exp_t;
    exp_t sb[$];

    int n_chk = 0, n_fail = 0, cyc = 0;
    int cur_w = 1, cur_div = 0, accept_cyc = 0, last_rise = 0, rises = 0, ack_seen = 0;
    bit cur_tx = 1'b0, oe_bad = 1'b0, sck_prev = 1'b0;
    logic [7:0] resp = '0, cap = '0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive_in();
        case (cur_w)
            4:       sdat_i = resp[7:4];
            2:       sdat_i = {2'b00, resp[7:6]};
            default: sdat_i = {2'b00, resp[7], ~resp[7]};
        endcase
    endtask

    function automatic int lane_mask(input int w);
        return (w == 4) ? 15 : (w == 2) ? 3 : 1;
    endfunction

    // Monitor: scoreboard pops, SCK timing, lane capture and slave drive
    always @(negedge clk) begin
        if (rst) begin
            sck_prev = 1'b0;
        end else begin
            if (rx_ack) begin
                ack_seen++;
                if (sb.size() == 0) begin
                    chk(1'b0, "R5 ack without pending receive", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(rx_data == e.b, "R5 received byte", rx_data, e.b);
                    chk(cyc == e.at, "R5 ack cycle", cyc, e.at);
                end
            end
            if (!cur_tx && !bus_idle && sdat_oe != 4'h0) oe_bad = 1'b1;
            if (sck && !sck_prev) begin
                if (rises == 0)
                    chk(cyc - accept_cyc == cur_div + 1, "R1 first rise delay", cyc - accept_cyc, cur_div + 1);
                else
                    chk(cyc - last_rise == 2 * (cur_div + 1), "R1 SCK period", cyc - last_rise, 2 * (cur_div + 1));
                last_rise = cyc;
                rises++;
                if (cur_tx) begin
                    chk(sdat_oe == 4'(lane_mask(cur_w)), "R2 lane enables", sdat_oe, lane_mask(cur_w));
                    case (cur_w)
                        4:       cap = {cap[3:0], sdat_o};
                        2:       cap = {cap[5:0], sdat_o[1:0]};
                        default: cap = {cap[6:0], sdat_o[0]};
                    endcase
                end
            end
            if (!sck && sck_prev) begin
                chk(cyc - last_rise == cur_div + 1, "R1 SCK high time", cyc - last_rise, cur_div + 1);
                resp = resp << cur_w;
                drive_in();
            end
            sck_prev = sck;
        end
    end

    task automatic issue(input logic [2:0] m, input logic [2:0] c, input int d,
                         input logic [7:0] tx, input logic [7:0] rx, input bit wait_end);
        int acks_before;
        int len;
        do begin @(negedge clk); #1; end while (!cmd_ready);
        cur_w   = (m[2:1] == 2'b11) ? 4 : (m[2:1] == 2'b10) ? 2 : 1;
        cur_div = d;
        cur_tx  = m[0];
        resp    = rx;
        drive_in();
        cap = '0; rises = 0; oe_bad = 1'b0;
        acks_before = ack_seen;
        div_i = 8'(d); cmd_mode = m; cmd_clks = c; cmd_txd = tx; cmd_valid = 1'b1;
        @(posedge clk); #1;
        cmd_valid  = 1'b0;
        accept_cyc = cyc;
        len = 2 * (d + 1) * (int'(c) + 1);
        if (!m[0]) sb.push_back('{b: int'(rx), at: accept_cyc + len});
        @(negedge clk);
        chk(!cmd_ready, "R4 ready low while shifting", cmd_ready, 0);
        chk(!bus_idle, "R7 busy after accept", bus_idle, 0);
        if (wait_end) begin
            while (!bus_idle) @(negedge clk);
            chk(cyc == accept_cyc + len, "R7 idle at last falling edge", cyc - accept_cyc, len);
            chk(rises == int'(c) + 1, "R3 SCK cycle count", rises, int'(c) + 1);
            chk(!oe_bad, "R6 enables low in receive", oe_bad, 0);
            if (m[0] && c == 3'(8 / cur_w - 1))
                chk(cap == tx, "R2 transmitted byte", cap, tx);
            if (m[0]) begin
                @(negedge clk);
                chk(ack_seen == acks_before, "R10 no ack for transmit", ack_seen - acks_before, 0);
            end
        end
    endtask

    initial begin
        int a_acc;
        int acks_mark;
        repeat (3) @(negedge clk);
        chk(!sck && sdat_oe == 4'h0 && bus_idle && cmd_ready && !rx_ack, "R9 reset state",
            {sck, sdat_oe, bus_idle, cmd_ready, rx_ack}, 8'h06);
        #1 rst = 1'b0;

        issue(3'b011, 3'b111, 2, 8'hA5, 8'h00, 1'b1);  // R2 single transmit
        issue(3'b101, 3'b011, 0, 8'h3C, 8'h00, 1'b1);  // R2 dual transmit
        issue(3'b111, 3'b001, 1, 8'h96, 8'h00, 1'b1);  // R2 quad transmit
        issue(3'b010, 3'b111, 1, 8'h00, 8'hC3, 1'b1);  // R5 single receive on lane 1
        issue(3'b100, 3'b011, 0, 8'h00, 8'h5A, 1'b1);  // R5 dual receive
        issue(3'b110, 3'b001, 3, 8'h00, 8'hE1, 1'b1);  // R5 quad receive
        issue(3'b011, 3'b010, 0, 8'h00, 8'h00, 1'b1);  // R10 three dummy clocks
        issue(3'b001, 3'b111, 0, 8'h00, 8'h00, 1'b1);  // R10 mode 00 eight idle clocks

        // R8 back-to-back: quad receive then dual transmit with no gap
        issue(3'b110, 3'b001, 0, 8'h00, 8'h7E, 1'b0);
        a_acc = accept_cyc;
        issue(3'b101, 3'b011, 0, 8'hC9, 8'h00, 1'b1);
        chk(accept_cyc == a_acc + 4 + 1, "R8 next accept without gap", accept_cyc - a_acc, 5);

        // R9 reset in the middle of a receive
        issue(3'b010, 3'b111, 3, 8'h00, 8'hFF, 1'b0);
        repeat (10) @(negedge clk);
        #1 rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        sb.delete();
        acks_mark = ack_seen;
        chk(!sck && sdat_oe == 4'h0 && bus_idle && cmd_ready, "R9 reset mid-command",
            {sck, sdat_oe, bus_idle, cmd_ready}, 4'h3);
        repeat (80) @(negedge clk);
        chk(ack_seen == acks_mark, "R9 pending ack cancelled", ack_seen - acks_mark, 0);
        issue(3'b100, 3'b011, 1, 8'h00, 8'h81, 1'b1);  // R9 recovery after reset
        repeat (4) @(negedge clk);
        chk(sb.size() == 0, "R5 all receives acknowledged", sb.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 100000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule